// File: doc/BRIEF.md
# Gated Interval Timer with Selectable Gate and Toggle Measurement

This block is a 16-bit up-counter whose advance is qualified by a gate. The gate is picked from four places: an external gate pin, a one-cycle pulse from a built-in 8-bit period timer, and two comparator results that arrive as plain digital levels. A polarity control decides which gate level lets the counter run, so the counter can time either the high or the low phase of a signal.

For whole-period measurement a toggle option routes the polarity-adjusted gate through a flip-flop that flips on each active rising edge of the gate; the counter then runs from one active edge to the next. While the option is off the flip-flop is forced to zero, so the first active edge after turning it on always opens the measurement window. A status output shows the gate value that is enabling the counter at that moment. A global gate-enable lets the counter free-run, a run control stops it altogether, a load port writes it, and a one-cycle flag marks each wrap.

Top module: `gt_gated_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter, the overflow flag, the period timer and the match pulse clear to zero.
- R2: With `tmr_on` low and `load_en` low, the counter holds its value on every edge.
- R3: With `tmr_on` high and `gate_en` low, the counter advances by one on every edge, whatever the gate does.
- R4: `gate_sel` picks the gate: 2'b00 the gate pin, 2'b01 the period-match pulse, 2'b10 comparator 1, 2'b11 comparator 2; unselected sources have no effect on counting.
- R5: With `gate_pol` high the counter advances while the selected gate is high; with `gate_pol` low it advances while the gate is low.
- R6: The pin and the comparators pass through two synchronizing flops: a level driven before clock edge 1 first changes the counter at edge 3.
- R7: The period timer counts up to `per_limit`, then returns to zero on the next edge; `per_match` is high for exactly the one cycle after each return, so it repeats every `per_limit`+1 cycles (every cycle when `per_limit` is zero).
- R8: With the match source and polarity high, the counter advances once per match; with polarity low it advances on every cycle except the match cycles.
- R9: With `toggle_en` high, the counter runs from one active rising gate edge to the next, so one gate period of P cycles adds exactly P counts.
- R10: While `toggle_en` is low the toggle flip-flop is held at zero; on turning it on with the gate already active, the effective gate reads zero until the next rising edge.
- R11: `gate_val` equals the polarity-adjusted gate without toggle mode and the toggle flip-flop in toggle mode.
- R12: The counter wraps from 16'hFFFF to 16'h0000 and `ovf` is high for the single cycle after the wrap.
- R13: `load_en` writes `load_val` into the counter on the next edge and takes priority over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_on | input | 1 | Run control for the main counter |
| gate_en | input | 1 | When high, counting is qualified by the gate |
| gate_sel | input | 2 | Gate source select |
| gate_pol | input | 1 | Active gate level (1 = high) |
| toggle_en | input | 1 | Toggle measurement option |
| gate_pin | input | 1 | Asynchronous external gate |
| cmp1_in | input | 1 | Asynchronous comparator 1 result |
| cmp2_in | input | 1 | Asynchronous comparator 2 result |
| per_run | input | 1 | Run control for the period timer |
| per_limit | input | 8 | Period timer terminal value |
| load_en | input | 1 | Counter write strobe |
| load_val | input | 16 | Counter write value |
| count | output | 16 | Main counter value |
| ovf | output | 1 | One-cycle wrap flag |
| gate_val | output | 1 | Effective gate now enabling the counter |
| per_match | output | 1 | Period-match pulse |

## Verification
The awkward case is toggle mode: the count must equal exactly one gate period, which needs both measured edges to see the same synchronizer and edge-detect latency, and it needs the flip-flop to start from zero. The stimulus first holds the pin active with the option off, turns the option on to show the flip-flop held clear, then drives a clean pin waveform of known period and compares the final count with that period. Match gating is reached by leaving the period timer to run over windows that are whole multiples of its period, so the expected counts do not depend on the starting phase.

// File: rtl/gt_pkg.sv
// Shared types and widths for the gated interval timer.
// Assumes: the gate-source encoding is fixed by the select field.
package gt_pkg;
    typedef enum logic [1:0] {
        GSRC_PIN   = 2'b00,
        GSRC_MATCH = 2'b01,
        GSRC_CMP1  = 2'b10,
        GSRC_CMP2  = 2'b11
    } gate_src_e;

    localparam int unsigned N_ASYNC = 3;  // pin, cmp1, cmp2
    localparam int unsigned IDX_PIN  = 0;
    localparam int unsigned IDX_CMP1 = 1;
    localparam int unsigned IDX_CMP2 = 2;
endpackage

// File: rtl/gt_sync.sv
// Multi-bit level synchronizer: each bit passes through STAGES flops.
// Assumes: bits are independent levels; no bus coherence is needed.
module gt_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the sampled levels down the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/gt_period_timer.sv
// Period timer: counts up to a limit, returns to zero on the next step and
// raises a one-cycle pulse in the cycle after the return.
// Assumes: the limit may change at any time; equality alone ends a period.
module gt_period_timer #(
    parameter int unsigned PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PER_W-1:0] limit,
    output logic             match_pulse
);
    logic [PER_W-1:0] cnt_q;
    logic             pulse_q;
    logic             at_end;

    assign at_end = (cnt_q == limit);

    // Advance the period count and flag each return to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (run) begin
                if (at_end) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign match_pulse = pulse_q;

    // R7: a pulse marks a fresh period start
    p_pulse_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> (cnt_q == '0));

    // R7: a pulse lasts one cycle unless the period is a single cycle
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_q && !at_end) |=> !pulse_q);
endmodule

// File: rtl/gt_gate_ctrl.sv
// Gate path: source select, polarity, and the optional toggle flip-flop.
// Assumes: async sources arrive already synchronized; the match pulse is
// already in the clock domain.
module gt_gate_ctrl
    import gt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  gate_src_e          sel,
    input  logic               pol,
    input  logic               toggle_en,
    input  logic [N_ASYNC-1:0] sync_src,
    input  logic               match_pulse,
    output logic               gate_eff
);
    logic raw_gate;
    logic act_gate;
    logic act_prev_q;
    logic tff_q;
    logic act_rise;

    // Pick the gate source.
    always_comb begin
        unique case (sel)
            GSRC_PIN:   raw_gate = sync_src[IDX_PIN];
            GSRC_MATCH: raw_gate = match_pulse;
            GSRC_CMP1:  raw_gate = sync_src[IDX_CMP1];
            default:    raw_gate = sync_src[IDX_CMP2];
        endcase
    end

    assign act_gate = pol ? raw_gate : ~raw_gate;
    assign act_rise = act_gate & ~act_prev_q;

    // Remember the last active-gate level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) act_prev_q <= 1'b0;
        else        act_prev_q <= act_gate;
    end

    // Toggle flip-flop, forced clear while the option is off.
    always_ff @(posedge clk) begin
        if (!rst_n || !toggle_en) tff_q <= 1'b0;
        else if (act_rise)        tff_q <= ~tff_q;
    end

    assign gate_eff = toggle_en ? tff_q : act_gate;

    // R10: flip-flop is clear after any cycle with the option off
    p_tff_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !toggle_en |=> !tff_q);

    // R9: in toggle mode the flip-flop only moves on an active rising edge
    p_tff_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (toggle_en && !act_rise) |=> (tff_q == $past(tff_q)));
endmodule

// File: rtl/gt_gated_timer.sv
// Top of the gated interval timer: synchronizes async gates, runs the
// period timer, forms the effective gate and drives the main counter.
// Assumes: load takes priority over counting; ovf follows the wrap edge.
module gt_gated_timer
    import gt_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned PER_W  = 8,
    parameter int unsigned SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_on,
    input  logic             gate_en,
    input  logic [1:0]       gate_sel,
    input  logic             gate_pol,
    input  logic             toggle_en,
    input  logic             gate_pin,
    input  logic             cmp1_in,
    input  logic             cmp2_in,
    input  logic             per_run,
    input  logic [PER_W-1:0] per_limit,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf,
    output logic             gate_val,
    output logic             per_match
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [N_ASYNC-1:0] async_in;
    logic [N_ASYNC-1:0] sync_out;
    logic               match_pulse;
    logic               gate_eff;
    logic               advance;
    logic [CNT_W-1:0]   cnt_q;
    logic               ovf_q;

    assign async_in[IDX_PIN]  = gate_pin;
    assign async_in[IDX_CMP1] = cmp1_in;
    assign async_in[IDX_CMP2] = cmp2_in;

    gt_sync #(.WIDTH(N_ASYNC), .STAGES(SYNC_N)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (async_in),
        .dout  (sync_out)
    );

    gt_period_timer #(.PER_W(PER_W)) per_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (per_run),
        .limit       (per_limit),
        .match_pulse (match_pulse)
    );

    gt_gate_ctrl gate_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (gate_src_e'(gate_sel)),
        .pol         (gate_pol),
        .toggle_en   (toggle_en),
        .sync_src    (sync_out),
        .match_pulse (match_pulse),
        .gate_eff    (gate_eff)
    );

    assign advance = tmr_on & (~gate_en | gate_eff);

    // Main counter with load priority and a one-cycle wrap flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            ovf_q <= 1'b0;
            if (load_en) begin
                cnt_q <= load_val;
            end else if (advance) begin
                cnt_q <= cnt_q + 1'b1;
                ovf_q <= (cnt_q == CNT_MAX);
            end
        end
    end

    assign count     = cnt_q;
    assign ovf       = ovf_q;
    assign gate_val  = gate_eff;
    assign per_match = match_pulse;

    // R2: stopped timer holds its value
    p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tmr_on && !load_en) |=> (count == $past(count)));

    // R12: the wrap flag only appears with a zero count
    p_ovf_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> (count == '0));

    // R13: a load always lands
    p_load_lands_r13: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count == $past(load_val)));

    // R3: ungated running timer steps by one
    p_free_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_on && !gate_en && !load_en) |=> (count == $past(count) + 1'b1));
endmodule

// File: tb/gt_gated_timer_tb_top.sv
`timescale 1ns/1ps
module gt_gated_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_on = 1'b0;
    logic        gate_en = 1'b0;
    logic [1:0]  gate_sel = 2'b00;
    logic        gate_pol = 1'b1;
    logic        toggle_en = 1'b0;
    logic        gate_pin = 1'b0;
    logic        cmp1_in = 1'b0;
    logic        cmp2_in = 1'b0;
    logic        per_run = 1'b0;
    logic [7:0]  per_limit = 8'd0;
    logic        load_en = 1'b0;
    logic [15:0] load_val = 16'd0;
    logic [15:0] count;
    logic        ovf;
    logic        gate_val;
    logic        per_match;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    gt_gated_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_on(tmr_on), .gate_en(gate_en),
        .gate_sel(gate_sel), .gate_pol(gate_pol), .toggle_en(toggle_en),
        .gate_pin(gate_pin), .cmp1_in(cmp1_in), .cmp2_in(cmp2_in),
        .per_run(per_run), .per_limit(per_limit), .load_en(load_en),
        .load_val(load_val), .count(count), .ovf(ovf),
        .gate_val(gate_val), .per_match(per_match)
    );

    // Vector: [7:6] sel, [5] pol, [4] pin, [3] cmp1, [2] cmp2, [1] gate_en, [0] counts
    localparam int NVEC = 12;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b00_1_1_0_0_1_1,  // R4/R5 pin high, active high
        8'b00_1_0_1_1_1_0,  // R4 pin low, comparators ignored
        8'b00_0_0_0_0_1_1,  // R5 pin low, active low
        8'b00_0_1_0_0_1_0,  // R5 pin high, active low
        8'b10_1_0_1_0_1_1,  // R4 cmp1 high
        8'b10_1_1_0_1_1_0,  // R4 cmp1 low, others ignored
        8'b11_1_0_0_1_1_1,  // R4 cmp2 high
        8'b11_1_1_1_0_1_0,  // R4 cmp2 low, others ignored
        8'b11_0_0_0_0_1_1,  // R5 cmp2 low, active low
        8'b00_1_0_0_0_0_1,  // R3 gate disabled: free run
        8'b10_0_0_1_0_1_0,  // R5 cmp1 high, active low
        8'b01_0_0_0_0_1_1   // R4 match source idle, active low
    };

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        load_en = 1'b1; load_val = v;
        cyc(1);
        load_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        int hits;
        int prev;
        int twice;
        cyc(3);
        chk("R1 count", count, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 per_match", per_match, 0);
        rst_n = 1'b1;
        tmr_on = 1'b1;

        // Table walk over static gate patterns.
        for (int i = 0; i < NVEC; i++) begin
            gate_sel = VEC[i][7:6]; gate_pol = VEC[i][5];
            gate_pin = VEC[i][4]; cmp1_in = VEC[i][3]; cmp2_in = VEC[i][2];
            gate_en = VEC[i][1];
            cyc(4);
            load(16'd0);
            cyc(10);
            chk($sformatf("R4/R5 vector %0d", i), count, VEC[i][0] ? 10 : 0);
        end

        // R11: gate_val follows adjusted gate.
        gate_sel = 2'b00; gate_pol = 1'b0; gate_pin = 1'b1; gate_en = 1'b1;
        cyc(4);
        chk("R11 gate_val low pol", gate_val, 0);
        gate_pol = 1'b1; #1;
        chk("R11 gate_val high pol", gate_val, 1);

        // R6: synchronizer latency.
        gate_pin = 1'b0; cyc(4);
        load(16'd0);
        gate_pin = 1'b1;
        cyc(2);
        chk("R6 no count after two edges", count, 0);
        cyc(1);
        chk("R6 count at third edge", count, 1);

        // R10: flip-flop held clear, gate already active.
        cyc(3);
        toggle_en = 1'b1; #1;
        chk("R10 gate_val clear on enable", gate_val, 0);
        load(16'd0);
        cyc(3);
        chk("R10 no count without edge", count, 0);

        // R9: full-period measurement, period 8.
        gate_pin = 1'b0; cyc(6);
        load(16'd0);
        gate_pin = 1'b1; cyc(3);
        chk("R11 toggled gate_val", gate_val, 1);
        gate_pin = 1'b0; cyc(5);
        gate_pin = 1'b1; cyc(3);
        gate_pin = 1'b0; cyc(5);
        cyc(6);
        chk("R9 one period counted", count, 8);
        toggle_en = 1'b0;

        // R7: period timer pulse spacing.
        per_limit = 8'd4; per_run = 1'b1; gate_sel = 2'b01;
        cyc(12);
        hits = 0; prev = 0; twice = 0;
        for (int k = 0; k < 50; k++) begin
            cyc(1);
            if (per_match) hits++;
            if (per_match && prev != 0) twice++;
            prev = per_match;
        end
        chk("R7 pulses per 50 cycles", hits, 10);
        chk("R7 pulse width one", twice, 0);

        // R8: match gating, both polarities.
        gate_pol = 1'b1; load(16'd0); cyc(50);
        chk("R8 pol1 counts per match", count, 10);
        gate_pol = 1'b0; load(16'd0); cyc(50);
        chk("R8 pol0 skips match cycles", count, 40);

        // R7: zero limit pulses every cycle.
        per_limit = 8'd0; gate_pol = 1'b1; cyc(300);
        load(16'd0); cyc(20);
        chk("R7 zero limit", count, 20);
        per_run = 1'b0;

        // R2: stopped counter.
        gate_en = 1'b0; tmr_on = 1'b0;
        load(16'd77); cyc(5);
        chk("R2 hold when off", count, 77);

        // R13: load priority over counting.
        tmr_on = 1'b1;
        load(16'h1234);
        chk("R13 load wins", count, 16'h1234);

        // R12: wrap and flag.
        load_en = 1'b1; load_val = 16'hFFFE; cyc(1); load_en = 1'b0;
        cyc(1);
        chk("R12 at max", count, 16'hFFFF);
        chk("R12 no flag before wrap", ovf, 0);
        cyc(1);
        chk("R12 wrapped", count, 0);
        chk("R12 flag", ovf, 1);
        cyc(1);
        chk("R12 flag one cycle", ovf, 0);
        chk("R3 after wrap", count, 1);

        // R1: reset mid-run.
        rst_n = 1'b0; cyc(1);
        chk("R1 count after reset", count, 0);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule